// File: doc/BRIEF.md
# Lockable Battery-Backed Register RAM

This block is a small byte-wide RAM of the kind that holds real-time-clock setup values. Software reaches it through an index/data register pair. It first writes an index, then reads or writes the byte at that index through the data port. The array keeps its contents across a hard reset, which models battery backing. No reset or initial value is applied to it.

Two 8-byte windows inside the array can each be protected by its own lock bit in a separate configuration register. Writing 1 to a lock bit sets it, and writing 0 leaves it as it was. Once a lock bit is set, only a hard reset clears it. While a window is locked, writes to it are dropped and reads from it return 8'hFF. Bytes outside both windows behave normally whatever the lock state. After a hard reset, software may lock the windows again.

Top module: `lockable_cmos_ram`

## Requirements
- R1: While `hardRstN` is low, `lockOut` is 2'b00. RAM contents written before the hard reset read back unchanged after it.
- R2: A byte whose index lies outside both windows reads back the last value written to it, whatever the value of `lockOut`.
- R3: A data write whose index falls in a locked window leaves the stored byte unchanged. The old value is visible once the window is unlocked by a hard reset.
- R4: A read whose index falls in a locked window returns 8'hFF on `dataOut`.
- R5: On a cycle with `cfgWe` high, each `cfgIn[i]` that is 1 sets lock bit i from the next cycle. A bit written as 0 keeps its current value, so a set bit stays set until hard reset.
- R6: After a hard reset, writing 1 to a lock bit locks its window again.
- R7: `idxWe` loads `idxIn` into the index register at the clock edge. A data write issued in the same cycle uses the index held before that edge. `dataOut` shows the byte at the current index, combinationally from the array.
- R8: Lock bit 0 guards indices BASE0..BASE0+7 (default 56..63) and lock bit 1 guards BASE1..BASE1+7 (default 64..71). Each bit affects only its own window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Active-low asynchronous hard reset; clears the lock bits and the index |
| idxWe | input | 1 | Load the index register |
| idxIn | input | ADDR_W (7) | New index value |
| dataWe | input | 1 | Write dataIn to the byte at the current index |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Byte at the current index, or 8'hFF if it is locked |
| cfgWe | input | 1 | Write to the lock configuration register |
| cfgIn | input | 2 | Lock bits to set (1 sets, 0 ignored) |
| lockOut | output | 2 | Current lock bits |

## Verification
The bench sweeps all 128 indices after each change of lock state, and the sweep includes the bytes on both sides of each window edge. A decoder that is off by one would mask index 55 or 72, or leave 63 or 64 readable. A design that still let writes into a locked window, or merely masked them on read, is caught after the hard reset: the window then shows its old contents rather than the newer patterns written while it was locked. The bench also checks these cases:
- A configuration write of 0 after a lock is set. A lock bit that was not sticky would clear here.
- The RAM contents after a hard reset. A design that reset the array would lose them.
- A data write in the same cycle as an index load. A write that used the new index would land at the wrong byte.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
  localparam int NUM_WIN = 2;
  localparam logic [7:0] MASK_BYTE = 8'hFF;

  typedef struct packed {
    logic ramWe;
    logic maskRd;
  } ctlStrb_t;
endpackage

// File: rtl/lcr_ctl.sv
module lcr_ctl
  import lcr_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int WIN_BYTES = 8,
  parameter int BASE0 = 56,
  parameter int BASE1 = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int OFF_W = $clog2(WIN_BYTES)
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              idxWe,
  input  logic [ADDR_W-1:0] idxIn,
  input  logic              dataWe,
  input  logic              cfgWe,
  input  logic [NUM_WIN-1:0] cfgIn,
  output logic [ADDR_W-1:0] idxQ,
  output logic [NUM_WIN-1:0] lockQ,
  output ctlStrb_t          strb
);
  logic [NUM_WIN-1:0] inWin;

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      idxQ  <= '0;
      lockQ <= '0;
    end else begin
      if (idxWe) idxQ <= idxIn;
      if (cfgWe) lockQ <= lockQ | cfgIn;
    end
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    localparam logic [ADDR_W-1:0] BaseV = ADDR_W'((i == 0) ? BASE0 : BASE1);
    assign inWin[i] = (idxQ[ADDR_W-1:OFF_W] == BaseV[ADDR_W-1:OFF_W]);
  end

  always_comb begin
    strb.maskRd = |(inWin & lockQ);
    strb.ramWe  = dataWe & ~strb.maskRd;
  end
endmodule

// File: rtl/lcr_dp.sv
module lcr_dp
  import lcr_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] idx,
  input  ctlStrb_t          strb,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.ramWe) mem[idx] <= dataIn;
  end

  assign dataOut = strb.maskRd ? MASK_BYTE : mem[idx];
endmodule

// File: rtl/lockable_cmos_ram.sv
module lockable_cmos_ram
  import lcr_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int WIN_BYTES = 8,
  parameter int BASE0 = 56,
  parameter int BASE1 = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              idxWe,
  input  logic [ADDR_W-1:0] idxIn,
  input  logic              dataWe,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  input  logic              cfgWe,
  input  logic [1:0]        cfgIn,
  output logic [1:0]        lockOut
);
  logic [ADDR_W-1:0] idxQ;
  ctlStrb_t strb;

  lcr_ctl #(.DEPTH(DEPTH), .WIN_BYTES(WIN_BYTES), .BASE0(BASE0), .BASE1(BASE1)) u_ctl (
    .clk(clk), .hardRstN(hardRstN), .idxWe(idxWe), .idxIn(idxIn),
    .dataWe(dataWe), .cfgWe(cfgWe), .cfgIn(cfgIn),
    .idxQ(idxQ), .lockQ(lockOut), .strb(strb)
  );

  lcr_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .idx(idxQ), .strb(strb), .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/lockable_cmos_ram_chk.sv
module lockable_cmos_ram_chk #(
  parameter int DEPTH = 128,
  parameter int WIN_BYTES = 8,
  parameter int BASE0 = 56,
  parameter int BASE1 = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              hardRstN,
  input logic              idxWe,
  input logic [ADDR_W-1:0] idxIn,
  input logic              dataWe,
  input logic [7:0]        dataIn,
  input logic [7:0]        dataOut,
  input logic              cfgWe,
  input logic [1:0]        cfgIn,
  input logic [1:0]        lockOut
);
  logic [ADDR_W-1:0] shIdx;
  logic w0, w1;

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) shIdx <= '0;
    else if (idxWe) shIdx <= idxIn;
  end

  assign w0 = (int'(shIdx) >= BASE0) && (int'(shIdx) < BASE0 + WIN_BYTES);
  assign w1 = (int'(shIdx) >= BASE1) && (int'(shIdx) < BASE1 + WIN_BYTES);

  // R1
  always @(posedge clk) begin
    if (!hardRstN) begin
      lock_clear_chk: assert (lockOut == 2'b00);
    end
  end

  // R4
  locked_read_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    ((lockOut[0] && w0) || (lockOut[1] && w1)) |-> dataOut == 8'hFF);

  // R5
  lock_sticky0_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    lockOut[0] |=> lockOut[0]);

  // R5
  lock_sticky1_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    lockOut[1] |=> lockOut[1]);

  // R5
  lock_set_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    cfgWe |=> (lockOut & $past(cfgIn)) == $past(cfgIn));

  // R2
  open_write_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    (dataWe && !idxWe && !w0 && !w1) |=> dataOut == $past(dataIn));
endmodule

bind lockable_cmos_ram lockable_cmos_ram_chk #(
  .DEPTH(DEPTH), .WIN_BYTES(WIN_BYTES), .BASE0(BASE0), .BASE1(BASE1)
) u_chk (
  .clk(clk), .hardRstN(hardRstN), .idxWe(idxWe), .idxIn(idxIn),
  .dataWe(dataWe), .dataIn(dataIn), .dataOut(dataOut),
  .cfgWe(cfgWe), .cfgIn(cfgIn), .lockOut(lockOut)
);

// File: tb/sim_lockable_cmos_ram.sv
`timescale 1ns/1ps
module sim_lockable_cmos_ram;
  localparam int DEPTH = 128;
  localparam int B0 = 56;
  localparam int B1 = 64;

  logic clk = 1'b0;
  logic hardRstN = 1'b0;
  logic idxWe = 1'b0, dataWe = 1'b0, cfgWe = 1'b0;
  logic [6:0] idxIn = '0;
  logic [7:0] dataIn = '0;
  logic [1:0] cfgIn = '0;
  logic [7:0] dataOut;
  logic [1:0] lockOut;

  int nChk = 0, nFail = 0;
  logic [7:0] expMem [DEPTH];
  logic [1:0] expLock = 2'b00;

  always #4 clk = ~clk;

  lockable_cmos_ram u0 (
    .clk(clk), .hardRstN(hardRstN), .idxWe(idxWe), .idxIn(idxIn),
    .dataWe(dataWe), .dataIn(dataIn), .dataOut(dataOut),
    .cfgWe(cfgWe), .cfgIn(cfgIn), .lockOut(lockOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input int a);
    if (expLock[0] && a >= B0 && a < B0 + 8) return 8'hFF;
    if (expLock[1] && a >= B1 && a < B1 + 8) return 8'hFF;
    return expMem[a];
  endfunction

  function automatic logic isLocked(input int a);
    return (expLock[0] && a >= B0 && a < B0 + 8) || (expLock[1] && a >= B1 && a < B1 + 8);
  endfunction

  task automatic setIdx(input int a);
    @(negedge clk); idxWe = 1'b1; idxIn = 7'(a);
    @(negedge clk); idxWe = 1'b0;
  endtask

  task automatic writeByte(input int a, input logic [7:0] d);
    setIdx(a);
    dataWe = 1'b1; dataIn = d;
    @(negedge clk); dataWe = 1'b0;
    if (!isLocked(a)) expMem[a] = d;
  endtask

  task automatic sweepRead(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      setIdx(a);
      check(req, dataOut, expRead(a));
    end
  endtask

  task automatic sweepWrite(input int mul, input int add);
    for (int a = 0; a < DEPTH; a++) writeByte(a, 8'((a * mul + add) & 255));
  endtask

  task automatic cfgWrite(input logic [1:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgIn = v;
    @(negedge clk); cfgWe = 1'b0;
    expLock = expLock | v;
  endtask

  task automatic hardReset();
    @(negedge clk); hardRstN = 1'b0;
    @(negedge clk);
    check("R1 lock clear", {6'b0, lockOut}, 8'h00);
    @(negedge clk); hardRstN = 1'b1;
    expLock = 2'b00;
  endtask

  initial begin
    #1;
    check("R1 reset lock", {6'b0, lockOut}, 8'h00);
    repeat (2) @(negedge clk);
    hardRstN = 1'b1;

    sweepWrite(37, 5);
    sweepRead("R2 open sweep");

    cfgWrite(2'b01);
    check("R5 set bit0", {6'b0, lockOut}, 8'h01);
    sweepRead("R4 R8 window0 locked");

    sweepWrite(91, 200);
    sweepRead("R3 R2 write while window0 locked");

    cfgWrite(2'b00);
    check("R5 zero ignored", {6'b0, lockOut}, 8'h01);

    cfgWrite(2'b10);
    check("R5 set bit1", {6'b0, lockOut}, 8'h03);
    sweepWrite(13, 77);
    sweepRead("R4 both locked");

    hardReset();
    sweepRead("R1 R3 contents kept after hard reset");

    cfgWrite(2'b11);
    check("R6 relock", {6'b0, lockOut}, 8'h03);
    sweepRead("R6 relocked sweep");

    writeByte(5, 8'h11);
    setIdx(5);
    @(negedge clk); idxWe = 1'b1; idxIn = 7'd10; dataWe = 1'b1; dataIn = 8'hAA;
    @(negedge clk); idxWe = 1'b0; dataWe = 1'b0;
    expMem[5] = 8'hAA;
    check("R7 index after load", dataOut, expMem[10]);
    setIdx(5);
    check("R7 write used old index", dataOut, 8'hAA);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #1500000;
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule